// File: doc/BRIEF.md
# Row Cache Migration Controller

This block sits between a request source and a DRAM made of two sub-arrays of different speed. The small, fast sub-array holds copies of whole rows of the large, slow sub-array. The controller keeps a set-associative tag store of the rows currently resident in the small array. For each row request it decides which of four cases applies: hit, miss into a free way, miss over a clean victim, or miss over a dirty victim. It then issues the matching sequence of commands to the memory side.

Each command is held on the command port until the memory side acknowledges it with a done pulse. Only one request is in flight at a time. The request port accepts a new row only after the last command of the current sequence has completed.

When a set is full, a runtime policy input chooses the victim in one of three ways:
- the way filled longest ago;
- the way with the fewest accesses since it was filled;
- the way whose last access lies furthest back.

Top module: `rcm_top`

## Requirements
- R1: A request whose row is resident issues exactly one command, op 1 (access small array), to the way holding the row, with case code 0.
- R2: A miss in a set with an invalid way issues op 2 (copy large to small), then op 1, both to the lowest invalid way, with case code 1. The set index is the low SET_W row bits and the tag is the remaining upper bits.
- R3: A miss in a full set whose victim is clean issues op 2, then op 1, to the victim way, with case code 2 and no op 3.
- R4: A miss in a full set whose victim is dirty issues op 3 (copy small to large) carrying the victim's own row address, then op 2, then op 1, all to the victim way, with case code 3.
- R5: An access with the write flag set marks its way dirty. A refill leaves the way clean.
- R6: With policy 0, the victim is the way filled earliest, regardless of later accesses.
- R7: With policy 1, the victim is the way with the fewest accesses since its fill. Ties go to the lowest way index.
- R8: With policy 2, the victim is the way whose most recent access is oldest.
- R9: Per-way access counters saturate at their maximum value instead of wrapping, and a refill clears them.
- R10: Request ready is low from the cycle after acceptance until the cycle after the final command's done. While any command is valid, ready is low.
- R11: A valid command keeps its op, way, row and case unchanged until done is seen.
- R12: After reset, ready is high, no command is valid and every way is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Victim policy: 0 fill order, 1 fewest uses, 2 oldest use |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_row_i | input | ROW_W | Requested row address |
| req_write_i | input | 1 | Request writes the row |
| cmd_valid_o | output | 1 | Command valid |
| cmd_op_o | output | 2 | 1 access small, 2 copy large to small, 3 copy small to large |
| cmd_way_o | output | WAY_W | Small-array way addressed |
| cmd_row_o | output | ROW_W | Large-array row involved |
| cmd_case_o | output | 2 | Access case 0..3 of the current request |
| cmd_done_i | input | 1 | Memory side completed the current command |

## Verification
On every cycle, the checker enforces the handshake rules: ready stays low while a command is pending, commands are held stable until done, a write-back is always followed by a fill, a fill by an access to the same way, and each case code is paired only with its allowed ops. Victim choice under each policy, counter saturation and clearing, and dirty tracking depend on the history of earlier requests. These can only be shown by the bench's directed sequences, which build a known set state and then check which way is evicted.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam logic [1:0] OP_ACCESS = 2'd1;
  localparam logic [1:0] OP_FILL   = 2'd2;
  localparam logic [1:0] OP_WBACK  = 2'd3;

  localparam logic [1:0] POL_FIFO = 2'd0;
  localparam logic [1:0] POL_LUFO = 2'd1;
  localparam logic [1:0] POL_EULO = 2'd2;

  localparam logic [1:0] CASE_HIT   = 2'd0;
  localparam logic [1:0] CASE_FREE  = 2'd1;
  localparam logic [1:0] CASE_CLEAN = 2'd2;
  localparam logic [1:0] CASE_DIRTY = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_WBACK = 3'd2,
    ST_FILL  = 3'd3,
    ST_ACC   = 3'd4
  } ctl_st_e;
endpackage

// File: rtl/rcm_tag_store.sv
module rcm_tag_store #(
  parameter int SET_W   = 2,
  parameter int TAG_W   = 8,
  parameter int WAYS    = 4,
  parameter int USE_W   = 2,
  parameter int STAMP_W = 12,
  localparam int SETS   = 1 << SET_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [SET_W-1:0]                   rd_set,
  input  logic [TAG_W-1:0]                   rd_tag,
  input  logic                               fill_en,
  input  logic                               touch_en,
  input  logic                               touch_write,
  input  logic [WAY_W-1:0]                   wr_way,
  input  logic [TAG_W-1:0]                   fill_tag,
  input  logic [STAMP_W-1:0]                 ins_stamp,
  input  logic [STAMP_W-1:0]                 rec_stamp,
  output logic [WAYS-1:0]                    valid_o,
  output logic [WAYS-1:0]                    dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]         tag_o,
  output logic [WAYS-1:0][USE_W-1:0]         cnt_o,
  output logic [WAYS-1:0][STAMP_W-1:0]       ins_o,
  output logic [WAYS-1:0][STAMP_W-1:0]       rec_o,
  output logic                               hit_o,
  output logic [WAY_W-1:0]                   hit_way_o
);
  localparam logic [USE_W-1:0] CNT_MAX = {USE_W{1'b1}};

  logic [SETS-1:0][WAYS-1:0]               vld_all, dty_all;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]    tag_all;
  logic [SETS-1:0][WAYS-1:0][USE_W-1:0]    cnt_all;
  logic [SETS-1:0][WAYS-1:0][STAMP_W-1:0]  ins_all, rec_all;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic               vld_r, vld_n, dty_r, dty_n, sel;
      logic [USE_W-1:0]   cnt_r, cnt_n;
      logic [TAG_W-1:0]   tag_r;
      logic [STAMP_W-1:0] ins_r, rec_r;

      assign sel = (rd_set == SET_W'(s)) && (wr_way == WAY_W'(w));

      always_comb begin
        vld_n = vld_r;
        dty_n = dty_r;
        cnt_n = cnt_r;
        if (fill_en && sel) begin
          vld_n = 1'b1;
          dty_n = 1'b0;
          cnt_n = '0;
        end else if (touch_en && sel) begin
          if (touch_write) dty_n = 1'b1;
          if (cnt_r != CNT_MAX) cnt_n = cnt_r + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_r <= 1'b0;
          dty_r <= 1'b0;
          cnt_r <= '0;
        end else begin
          vld_r <= vld_n;
          dty_r <= dty_n;
          cnt_r <= cnt_n;
        end
      end

      always_ff @(posedge clk) begin
        if (fill_en && sel) begin
          tag_r <= fill_tag;
          ins_r <= ins_stamp;
        end
        if (touch_en && sel) rec_r <= rec_stamp;
      end

      assign vld_all[s][w] = vld_r;
      assign dty_all[s][w] = dty_r;
      assign tag_all[s][w] = tag_r;
      assign cnt_all[s][w] = cnt_r;
      assign ins_all[s][w] = ins_r;
      assign rec_all[s][w] = rec_r;
    end
  end

  assign valid_o = vld_all[rd_set];
  assign dirty_o = dty_all[rd_set];
  assign tag_o   = tag_all[rd_set];
  assign cnt_o   = cnt_all[rd_set];
  assign ins_o   = ins_all[rd_set];
  assign rec_o   = rec_all[rd_set];

  logic [WAYS-1:0] match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_o[w] && (tag_o[w] == rd_tag);
  end

  assign hit_o = |match;

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/rcm_victim_sel.sv
module rcm_victim_sel
  import rcm_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int USE_W   = 2,
  parameter int STAMP_W = 12,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic [1:0]                   policy,
  input  logic [WAYS-1:0]              valid,
  input  logic [WAYS-1:0][USE_W-1:0]   cnt,
  input  logic [WAYS-1:0][STAMP_W-1:0] ins,
  input  logic [WAYS-1:0][STAMP_W-1:0] rec,
  input  logic [STAMP_W-1:0]           ins_now,
  input  logic [STAMP_W-1:0]           rec_now,
  output logic [WAY_W-1:0]             victim_way,
  output logic                         full_o
);
  logic [WAYS-1:0][STAMP_W-1:0] score;

  for (genvar w = 0; w < WAYS; w++) begin : g_score
    logic [STAMP_W-1:0] ins_age, rec_age, cnt_inv;
    assign ins_age = ins_now - ins[w];
    assign rec_age = rec_now - rec[w];
    assign cnt_inv = STAMP_W'(~cnt[w]);
    always_comb begin
      case (policy)
        POL_LUFO: score[w] = cnt_inv;
        POL_EULO: score[w] = rec_age;
        default:  score[w] = ins_age;
      endcase
    end
  end

  logic               free_found;
  logic [WAY_W-1:0]   free_way, best_way;
  logic [STAMP_W-1:0] best_score;

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid[w] && !free_found) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
    best_way   = '0;
    best_score = score[0];
    for (int w = 1; w < WAYS; w++) begin
      if (score[w] > best_score) begin
        best_score = score[w];
        best_way   = WAY_W'(w);
      end
    end
  end

  assign victim_way = free_found ? free_way : best_way;
  assign full_o     = &valid;
endmodule

// File: rtl/rcm_ctrl.sv
module rcm_ctrl
  import rcm_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int SET_W   = 2,
  parameter int WAYS    = 4,
  parameter int STAMP_W = 12,
  localparam int TAG_W  = ROW_W - SET_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ROW_W-1:0]   req_row_i,
  input  logic               req_write_i,
  output logic               cmd_valid_o,
  output logic [1:0]         cmd_op_o,
  output logic [WAY_W-1:0]   cmd_way_o,
  output logic [ROW_W-1:0]   cmd_row_o,
  output logic [1:0]         cmd_case_o,
  input  logic               cmd_done_i,
  input  logic               hit,
  input  logic [WAY_W-1:0]   hit_way,
  input  logic               full,
  input  logic [WAY_W-1:0]   victim_way,
  input  logic               victim_dirty,
  input  logic [TAG_W-1:0]   victim_tag,
  output logic [ROW_W-1:0]   look_row,
  output logic               fill_en,
  output logic               touch_en,
  output logic               touch_write,
  output logic [STAMP_W-1:0] ins_now,
  output logic [STAMP_W-1:0] rec_now
);
  ctl_st_e            st_q, st_d;
  logic [ROW_W-1:0]   row_q, row_d;
  logic               wr_q, wr_d;
  logic [WAY_W-1:0]   way_q, way_d;
  logic [1:0]         case_q, case_d;
  logic [TAG_W-1:0]   vtag_q, vtag_d;
  logic [STAMP_W-1:0] ins_q, ins_d, rec_q, rec_d;

  always_comb begin
    st_d   = st_q;
    row_d  = row_q;
    wr_d   = wr_q;
    way_d  = way_q;
    case_d = case_q;
    vtag_d = vtag_q;
    ins_d  = ins_q;
    rec_d  = rec_q;
    case (st_q)
      ST_IDLE: if (req_valid_i) begin
        row_d = req_row_i;
        wr_d  = req_write_i;
        st_d  = ST_LOOK;
      end
      ST_LOOK: begin
        if (hit) begin
          way_d  = hit_way;
          case_d = CASE_HIT;
          st_d   = ST_ACC;
        end else begin
          way_d = victim_way;
          if (!full) begin
            case_d = CASE_FREE;
            st_d   = ST_FILL;
          end else if (victim_dirty) begin
            case_d = CASE_DIRTY;
            vtag_d = victim_tag;
            st_d   = ST_WBACK;
          end else begin
            case_d = CASE_CLEAN;
            st_d   = ST_FILL;
          end
        end
      end
      ST_WBACK: if (cmd_done_i) st_d = ST_FILL;
      ST_FILL: if (cmd_done_i) begin
        st_d  = ST_ACC;
        ins_d = ins_q + 1'b1;
      end
      ST_ACC: if (cmd_done_i) begin
        st_d  = ST_IDLE;
        rec_d = rec_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      row_q  <= '0;
      wr_q   <= 1'b0;
      way_q  <= '0;
      case_q <= '0;
      vtag_q <= '0;
      ins_q  <= '0;
      rec_q  <= '0;
    end else begin
      st_q   <= st_d;
      row_q  <= row_d;
      wr_q   <= wr_d;
      way_q  <= way_d;
      case_q <= case_d;
      vtag_q <= vtag_d;
      ins_q  <= ins_d;
      rec_q  <= rec_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_WBACK: cmd_op_o = OP_WBACK;
      ST_FILL:  cmd_op_o = OP_FILL;
      ST_ACC:   cmd_op_o = OP_ACCESS;
      default:  cmd_op_o = 2'd0;
    endcase
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cmd_valid_o = (st_q == ST_WBACK) || (st_q == ST_FILL) || (st_q == ST_ACC);
  assign cmd_way_o   = way_q;
  assign cmd_case_o  = case_q;
  assign cmd_row_o   = (st_q == ST_WBACK) ? {vtag_q, row_q[SET_W-1:0]} : row_q;
  assign look_row    = row_q;
  assign fill_en     = (st_q == ST_FILL) && cmd_done_i;
  assign touch_en    = (st_q == ST_ACC) && cmd_done_i;
  assign touch_write = wr_q;
  assign ins_now     = ins_q;
  assign rec_now     = rec_q;
endmodule

// File: rtl/rcm_top.sv
module rcm_top #(
  parameter int ROW_W   = 10,
  parameter int SET_W   = 2,
  parameter int WAYS    = 4,
  parameter int USE_W   = 2,
  parameter int STAMP_W = 12,
  localparam int TAG_W  = ROW_W - SET_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic             req_write_i,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [WAY_W-1:0] cmd_way_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [1:0]       cmd_case_o,
  input  logic             cmd_done_i
);
  logic [ROW_W-1:0]             look_row;
  logic                         fill_en, touch_en, touch_write;
  logic [STAMP_W-1:0]           ins_now, rec_now;
  logic [WAYS-1:0]              valid_v, dirty_v;
  logic [WAYS-1:0][TAG_W-1:0]   tag_v;
  logic [WAYS-1:0][USE_W-1:0]   cnt_v;
  logic [WAYS-1:0][STAMP_W-1:0] ins_v, rec_v;
  logic                         hit, full;
  logic [WAY_W-1:0]             hit_way, victim_way;

  rcm_tag_store #(
    .SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS), .USE_W(USE_W), .STAMP_W(STAMP_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_set(look_row[SET_W-1:0]), .rd_tag(look_row[ROW_W-1:SET_W]),
    .fill_en(fill_en), .touch_en(touch_en), .touch_write(touch_write),
    .wr_way(cmd_way_o), .fill_tag(look_row[ROW_W-1:SET_W]),
    .ins_stamp(ins_now), .rec_stamp(rec_now),
    .valid_o(valid_v), .dirty_o(dirty_v), .tag_o(tag_v), .cnt_o(cnt_v),
    .ins_o(ins_v), .rec_o(rec_v), .hit_o(hit), .hit_way_o(hit_way)
  );

  rcm_victim_sel #(
    .WAYS(WAYS), .USE_W(USE_W), .STAMP_W(STAMP_W)
  ) u_victim (
    .policy(policy_i), .valid(valid_v), .cnt(cnt_v), .ins(ins_v), .rec(rec_v),
    .ins_now(ins_now), .rec_now(rec_now), .victim_way(victim_way), .full_o(full)
  );

  rcm_ctrl #(
    .ROW_W(ROW_W), .SET_W(SET_W), .WAYS(WAYS), .STAMP_W(STAMP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_row_i(req_row_i), .req_write_i(req_write_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_way_o(cmd_way_o),
    .cmd_row_o(cmd_row_o), .cmd_case_o(cmd_case_o), .cmd_done_i(cmd_done_i),
    .hit(hit), .hit_way(hit_way), .full(full), .victim_way(victim_way),
    .victim_dirty(dirty_v[victim_way]), .victim_tag(tag_v[victim_way]),
    .look_row(look_row), .fill_en(fill_en), .touch_en(touch_en),
    .touch_write(touch_write), .ins_now(ins_now), .rec_now(rec_now)
  );
endmodule

// File: rtl/rcm_chk.sv
module rcm_chk
  import rcm_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic [WAY_W-1:0] cmd_way_o,
  input logic [ROW_W-1:0] cmd_row_o,
  input logic [1:0]       cmd_case_o,
  input logic             cmd_done_i
);
  // R10
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> !req_ready_o);

  // R10
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_op_o) &&
      $stable(cmd_way_o) && $stable(cmd_row_o) && $stable(cmd_case_o));

  // R4
  wback_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_op_o == OP_WBACK && cmd_done_i |=>
      cmd_valid_o && cmd_op_o == OP_FILL && $stable(cmd_way_o));

  // R2
  fill_then_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_op_o == OP_FILL && cmd_done_i |=>
      cmd_valid_o && cmd_op_o == OP_ACCESS && $stable(cmd_way_o));

  // R1
  hit_access_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_case_o == CASE_HIT |-> cmd_op_o == OP_ACCESS);

  // R3
  clean_no_wback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_case_o != CASE_DIRTY |-> cmd_op_o != OP_WBACK);

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> req_ready_o && !cmd_valid_o);
endmodule

bind rcm_top rcm_chk #(.ROW_W(ROW_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_way_o(cmd_way_o),
  .cmd_row_o(cmd_row_o), .cmd_case_o(cmd_case_o), .cmd_done_i(cmd_done_i)
);

// File: tb/rcm_top_tb.sv
`timescale 1ns/1ps
module rcm_top_tb;
  localparam int ROW_W = 10;
  localparam int WAY_W = 2;
  localparam logic [1:0] OPA = 2'd1, OPF = 2'd2, OPW = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       policy;
  logic             req_valid, req_write, cmd_done;
  logic [ROW_W-1:0] req_row;
  logic             req_ready, cmd_valid;
  logic [1:0]       cmd_op, cmd_case;
  logic [WAY_W-1:0] cmd_way;
  logic [ROW_W-1:0] cmd_row;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  rcm_top u_dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_row_i(req_row),
    .req_write_i(req_write), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_way_o(cmd_way), .cmd_row_o(cmd_row), .cmd_case_o(cmd_case),
    .cmd_done_i(cmd_done)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] pol);
    policy = pol; req_valid = 0; req_write = 0; req_row = '0; cmd_done = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // One request: row = tag*4 + set. Expected command list, way, write-back row, case.
  task automatic req(input int tag, input int set, input bit wr, input int en,
                     input logic [1:0] e0, input logic [1:0] e1, input logic [1:0] e2,
                     input int eway, input int ewb, input int ecase, input string rq);
    logic [1:0] gop [3];
    int gway [3];
    int grow [3];
    int gcase, n;
    bit fin, rdy_bad, hold_bad;
    logic [ROW_W-1:0] row;
    row = ROW_W'(tag * 4 + set);
    n = 0; fin = 0; rdy_bad = 0; hold_bad = 0; gcase = -1;
    chk(req_ready == 1'b1, rq, "ready before request", int'(req_ready), 1);
    req_valid = 1; req_row = row; req_write = wr;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    while (!fin) begin
      if (req_ready) begin rdy_bad = 1; fin = 1; end
      else if (cmd_valid) begin
        if (n < 3) begin
          gop[n] = cmd_op; gway[n] = int'(cmd_way); grow[n] = int'(cmd_row);
          if (n == 0) gcase = int'(cmd_case);
        end
        @(negedge clk);
        if (!cmd_valid || cmd_op != gop[n > 2 ? 2 : n] ||
            int'(cmd_row) != grow[n > 2 ? 2 : n]) hold_bad = 1;
        cmd_done = 1;
        if (cmd_op == OPA) fin = 1;
        @(negedge clk);
        cmd_done = 0;
        n++;
        if (n > 3) fin = 1;
      end else @(negedge clk);
    end
    chk(!rdy_bad, {rq, " R10"}, "ready high mid-sequence", int'(rdy_bad), 0);
    chk(!hold_bad, {rq, " R11"}, "command changed before done", int'(hold_bad), 0);
    chk(n == en, rq, "command count", n, en);
    chk(gcase == ecase, rq, "case code", gcase, ecase);
    if (n == en) begin
      for (int i = 0; i < en; i++) begin
        logic [1:0] e;
        e = (i == 0) ? e0 : (i == 1) ? e1 : e2;
        chk(gop[i] == e, rq, $sformatf("op %0d", i), int'(gop[i]), int'(e));
        chk(gway[i] == eway, rq, $sformatf("way %0d", i), gway[i], eway);
        if (gop[i] == OPW) chk(grow[i] == ewb, rq, "write-back row", grow[i], ewb);
        else chk(grow[i] == int'(row), rq, "row", grow[i], int'(row));
      end
    end
    chk(req_ready == 1'b1, {rq, " R10"}, "ready after sequence", int'(req_ready), 1);
  endtask

  task automatic fill_four();
    for (int t = 1; t <= 4; t++)
      req(t, 0, 0, 2, OPF, OPA, 0, t - 1, 0, 1, "R2 fill free way");
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    chk(req_ready == 1'b1, "R12", "ready after reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R12", "cmd valid after reset", int'(cmd_valid), 0);
    req(1, 0, 0, 2, OPF, OPA, 0, 0, 0, 1, "R12 first miss to way 0");
  endtask

  task automatic t_fifo();
    do_reset(2'd0);
    req(1, 0, 0, 2, OPF, OPA, 0, 0, 0, 1, "R2 miss free");
    req(1, 0, 0, 1, OPA, 0, 0, 0, 0, 0, "R1 hit");
    req(1, 1, 0, 2, OPF, OPA, 0, 0, 0, 1, "R2 other set way 0");
    for (int t = 2; t <= 4; t++)
      req(t, 0, 0, 2, OPF, OPA, 0, t - 1, 0, 1, "R2 next free way");
    req(1, 0, 0, 1, OPA, 0, 0, 0, 0, 0, "R1 hit way 0");
    req(5, 0, 0, 2, OPF, OPA, 0, 0, 0, 2, "R3 R6 oldest fill");
    req(6, 0, 0, 2, OPF, OPA, 0, 1, 0, 2, "R6 next oldest fill");
    req(5, 0, 0, 1, OPA, 0, 0, 0, 0, 0, "R1 refilled row hits");
  endtask

  task automatic t_dirty();
    do_reset(2'd0);
    req(1, 0, 1, 2, OPF, OPA, 0, 0, 0, 1, "R5 write miss");
    for (int t = 2; t <= 4; t++)
      req(t, 0, 0, 2, OPF, OPA, 0, t - 1, 0, 1, "R2 fill");
    req(5, 0, 0, 3, OPW, OPF, OPA, 0, 4, 3, "R4 dirty victim");
    do_reset(2'd0);
    fill_four();
    req(2, 0, 1, 1, OPA, 0, 0, 1, 0, 0, "R5 write hit");
    req(5, 0, 0, 2, OPF, OPA, 0, 0, 0, 2, "R3 clean victim");
    req(6, 0, 0, 3, OPW, OPF, OPA, 1, 8, 3, "R5 write hit made dirty");
    req(7, 0, 0, 2, OPF, OPA, 0, 2, 0, 2, "R3 clean");
    req(8, 0, 0, 2, OPF, OPA, 0, 3, 0, 2, "R3 clean");
    req(9, 0, 0, 2, OPF, OPA, 0, 0, 0, 2, "R5 refill left clean");
    req(10, 0, 0, 2, OPF, OPA, 0, 1, 0, 2, "R5 refill after writeback clean");
  endtask

  task automatic t_lufo();
    do_reset(2'd1);
    fill_four();
    req(1, 0, 0, 1, OPA, 0, 0, 0, 0, 0, "R1 hit");
    req(1, 0, 0, 1, OPA, 0, 0, 0, 0, 0, "R1 hit");
    req(2, 0, 0, 1, OPA, 0, 0, 1, 0, 0, "R1 hit");
    req(4, 0, 0, 1, OPA, 0, 0, 3, 0, 0, "R1 hit");
    req(4, 0, 0, 1, OPA, 0, 0, 3, 0, 0, "R1 hit");
    req(5, 0, 0, 2, OPF, OPA, 0, 2, 0, 2, "R7 fewest uses");
    req(5, 0, 0, 1, OPA, 0, 0, 2, 0, 0, "R1 hit");
    req(6, 0, 0, 2, OPF, OPA, 0, 1, 0, 2, "R7 tie lowest way");
  endtask

  task automatic t_sat();
    do_reset(2'd1);
    fill_four();
    for (int i = 0; i < 3; i++) req(1, 0, 0, 1, OPA, 0, 0, 0, 0, 0, "R1 hit");
    req(2, 0, 0, 1, OPA, 0, 0, 1, 0, 0, "R1 hit");
    for (int i = 0; i < 2; i++) req(3, 0, 0, 1, OPA, 0, 0, 2, 0, 0, "R1 hit");
    for (int i = 0; i < 2; i++) req(4, 0, 0, 1, OPA, 0, 0, 3, 0, 0, "R1 hit");
    req(5, 0, 0, 2, OPF, OPA, 0, 1, 0, 2, "R9 counter saturates");
    req(6, 0, 0, 2, OPF, OPA, 0, 1, 0, 2, "R9 refill clears counter");
  endtask

  task automatic t_eulo();
    do_reset(2'd2);
    fill_four();
    req(1, 0, 0, 1, OPA, 0, 0, 0, 0, 0, "R1 hit");
    req(5, 0, 0, 2, OPF, OPA, 0, 1, 0, 2, "R8 oldest use");
    req(3, 0, 0, 1, OPA, 0, 0, 2, 0, 0, "R1 hit");
    req(6, 0, 0, 2, OPF, OPA, 0, 3, 0, 2, "R8 oldest use after hits");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_fifo();
    t_dirty();
    t_lufo();
    t_sat();
    t_eulo();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule